// File: doc/BRIEF.md
# Mailbox Register Region with Doorbell Handshake

This block is the memory-mapped mailbox window of a memory-expansion device. A host reaches it through a simple register bus: an address, 64 bits of write data, a size code, and separate write and read strobes. The window holds a capability word, a control word with a doorbell bit, a 64-bit command word, a 64-bit status word, a reserved background-status word and a byte-addressable payload buffer. All data is little-endian, and every access must be aligned to its own width.

Software fills the payload and the command word, then sets the doorbell. The block raises a request towards a command engine outside the block and keeps it high. When the engine pulses completion, the block stores the engine's return code in the status word and clears the doorbell, so software can poll the control word to see that the command has finished. While a command is in flight, the command word and the payload are frozen against host writes.

Top module: `mbox_regfile`

## Requirements
- R1: After reset the control, command and status words and every payload byte read as zero, `eng_req` is low, and the capability word reads 0x0000000B.
- R2: The capability word sits at offset 0x00. Bits 4:0 hold log2 of the payload size (11 for 2048 bytes), bit 5 (interrupt support) and bit 6 (background-command support) are 0, and all other bits are 0.
- R3: `bus_size` 0, 1, 2, 3 selects 1, 2, 4, 8 bytes. A read returns the addressed bytes little-endian in the low bytes of `bus_rdata`, upper bytes zero, in the cycle after the edge that samples `bus_rd`.
- R4: An access whose address is not a multiple of its width, or that reaches past offset 0x81F, has no effect when written and returns zero when read.
- R5: Below offset 0x20 a 4-byte write updates only the capability word (0x00) or the control word (0x04). A 4-byte write to any other offset, and any 1- or 2-byte write below 0x20, is ignored.
- R6: Below offset 0x20 an 8-byte write updates only the command word (0x08). 8-byte writes to the status word (0x10) and the background-status word (0x18) are ignored, and both words read zero until a completion writes the status word.
- R7: A write of any legal size at offset 0x20 or above copies its bytes into the payload (payload byte n is offset 0x20+n) and never raises `eng_req`.
- R8: Control bit 0 is the doorbell. A register write that leaves the doorbell at 1 raises `eng_req` at the edge that takes the write. `eng_req` stays high until completion, and a host write cannot clear the doorbell.
- R9: When `eng_done` is high while `eng_req` is high, the same edge writes `eng_rc` into status bits 47:32 with all other status bits zero, clears the doorbell and drops `eng_req`.
- R10: While the doorbell is set, host writes to the command word and to the payload are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte offset inside the mailbox window |
| bus_size | input | 2 | Access width code: 0=1, 1=2, 2=4, 3=8 bytes |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 64 | Write data, little-endian, low bytes used |
| bus_rdata | output | 64 | Read data, registered, upper bytes zero |
| eng_req | output | 1 | Request to the command engine to process the mailbox |
| eng_done | input | 1 | One-cycle completion pulse from the command engine |
| eng_rc | input | 16 | Return code stored into the status word on completion |

## Verification
A write is taken on the clock edge that samples `bus_wr`, so its effect on registers and on `eng_req` is visible right after that edge. Read data arrives one edge after `bus_rd` is sampled. Completion acts on the edge that samples `eng_done`. The bench changes inputs on the falling edge, holds each strobe for exactly one rising edge, and samples outputs at the following falling edge. Each result is therefore read in the first cycle where it is due, and no result depends on the order of events at the rising edge.

// File: rtl/mbox_pkg.sv
// Package: offsets, size codes and helpers shared by the mailbox region.
// Assumes the register block ends on an 8-byte boundary so that no aligned
// access straddles registers and payload.
package mbox_pkg;

    localparam int unsigned OFF_CAP   = 0;
    localparam int unsigned OFF_CTRL  = 4;
    localparam int unsigned OFF_CMD   = 8;
    localparam int unsigned OFF_STS   = 16;
    localparam int unsigned OFF_BGSTS = 24;
    localparam int unsigned PAY_BASE  = 32;

    localparam int unsigned DB_BIT    = 0;
    localparam int unsigned RC_LSB    = 32;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    // Number of bytes moved by a given size code.
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/mbox_access_dec.sv
// Module: mbox_access_dec
// Classifies one bus access: checks width alignment and the window bound,
// and splits legal writes into register writes and payload writes.
// Assumes PAY_BASE is a multiple of 8.
module mbox_access_dec
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned PAY_BYTES = 2048,
    localparam int unsigned PAY_AW   = $clog2(PAY_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              wr,
    output logic              legal,
    output logic              is_pay,
    output logic              reg_wr,
    output logic              pay_wr,
    output logic [3:0]        nbytes,
    output logic [PAY_AW-1:0] pay_off
);
    localparam int unsigned REGION = PAY_BASE + PAY_BYTES;

    logic [ADDR_W:0] end_addr;
    logic [2:0]      low_mask;
    logic            aligned;
    logic            in_range;

    // Width, alignment and range of the current access.
    always_comb begin
        nbytes   = size_bytes(size);
        low_mask = 3'(nbytes - 4'd1);
        aligned  = (addr[2:0] & low_mask) == 3'd0;
        end_addr = {1'b0, addr} + (ADDR_W+1)'(nbytes);
        in_range = end_addr <= (ADDR_W+1)'(REGION);
        legal    = aligned && in_range;
    end

    // Target selection and offset into the payload buffer.
    always_comb begin
        is_pay  = addr >= ADDR_W'(PAY_BASE);
        pay_off = PAY_AW'(addr - ADDR_W'(PAY_BASE));
        reg_wr  = wr && legal && !is_pay;
        pay_wr  = wr && legal && is_pay;
    end

endmodule

// File: rtl/mbox_ctrl_regs.sv
// Module: mbox_ctrl_regs
// Holds capability, control, command and status words, applies the
// width-based write filter, and runs the doorbell/engine handshake.
// Assumes reg_wr only for legal aligned accesses below the payload base.
module mbox_ctrl_regs
    import mbox_pkg::*;
#(
    parameter int unsigned PAY_BYTES = 2048,
    parameter int unsigned RC_W      = 16,
    localparam int unsigned PAY_LOG2 = $clog2(PAY_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [4:0]      reg_off,
    input  logic [1:0]      size,
    input  logic [63:0]     wdata,
    input  logic            eng_done,
    input  logic [RC_W-1:0] eng_rc,
    output logic [31:0]     cap_q,
    output logic [31:0]     ctrl_q,
    output logic [63:0]     cmd_q,
    output logic [63:0]     sts_q,
    output logic            eng_req
);
    localparam logic [31:0] CAP_RESET = 32'(PAY_LOG2);

    logic        wr_cap;
    logic        wr_ctrl;
    logic        wr_cmd;
    logic        complete;
    logic [31:0] ctrl_next;
    logic [63:0] sts_done;

    // Decode which register a filtered write may touch.
    always_comb begin
        wr_cap  = reg_wr && (size == SZ_WORD)  && (reg_off == 5'(OFF_CAP));
        wr_ctrl = reg_wr && (size == SZ_WORD)  && (reg_off == 5'(OFF_CTRL));
        wr_cmd  = reg_wr && (size == SZ_DWORD) && (reg_off == 5'(OFF_CMD))
                  && !ctrl_q[DB_BIT];
        complete = eng_req && eng_done;
    end

    // Control value after a host write; the doorbell cannot be cleared by it.
    always_comb begin
        ctrl_next = ctrl_q;
        if (wr_ctrl) begin
            ctrl_next = wdata[31:0];
            ctrl_next[DB_BIT] = wdata[DB_BIT] | ctrl_q[DB_BIT];
        end
    end

    // Status image written on completion.
    always_comb begin
        sts_done = '0;
        sts_done[RC_LSB +: RC_W] = eng_rc;
    end

    // Register state and handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q   <= CAP_RESET;
            ctrl_q  <= '0;
            cmd_q   <= '0;
            sts_q   <= '0;
            eng_req <= 1'b0;
        end else begin
            if (wr_cap)
                cap_q <= wdata[31:0];
            ctrl_q <= ctrl_next;
            if (wr_cmd)
                cmd_q <= wdata;
            if (complete) begin
                sts_q          <= sts_done;
                ctrl_q[DB_BIT] <= 1'b0;
                eng_req        <= 1'b0;
            end else if (reg_wr && ctrl_next[DB_BIT]) begin
                eng_req <= 1'b1;
            end
        end
    end

    // R9: completion drops the request and the doorbell on the next cycle.
    p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_done) |=> (!eng_req && !ctrl_q[DB_BIT]));

    // R9: status changes only through a completion.
    p_sts_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_req && eng_done) |=> $stable(sts_q));

    // R10: command word is frozen while the doorbell is set.
    p_cmd_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[DB_BIT] |=> $stable(cmd_q));

    // R8: the doorbell stays set until a completion.
    p_db_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[DB_BIT] && !(eng_req && eng_done)) |=> ctrl_q[DB_BIT]);

endmodule

// File: rtl/mbox_payload_buf.sv
// Module: mbox_payload_buf
// Byte-addressed payload store with an up-to-8-byte write port and an
// 8-byte read window. Writes are dropped while lock is high.
// Assumes wr_off/nbytes were range-checked by the decoder.
module mbox_payload_buf #(
    parameter int unsigned PAY_BYTES = 2048,
    localparam int unsigned PAY_AW   = $clog2(PAY_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              lock,
    input  logic [PAY_AW-1:0] off,
    input  logic [3:0]        nbytes,
    input  logic [63:0]       wdata,
    output logic [63:0]       rdata
);
    logic [7:0]        mem   [PAY_BYTES];
    logic [PAY_AW-1:0] idx   [8];
    logic              bsel  [8];
    logic              inb   [8];

    // Per-lane byte index and lane enables for the access window.
    always_comb begin
        for (int i = 0; i < 8; i++) begin
            idx[i]  = off + PAY_AW'(i);
            inb[i]  = (32'(off) + 32'(i)) < PAY_BYTES;
            bsel[i] = wr_en && !lock && (4'(i) < nbytes) && inb[i];
        end
    end

    // Byte writes into the store; reset clears every byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < PAY_BYTES; j++)
                mem[j] <= '0;
        end else begin
            for (int i = 0; i < 8; i++)
                if (bsel[i])
                    mem[idx[i]] <= wdata[i*8 +: 8];
        end
    end

    // Read window of eight consecutive bytes, zero past the end.
    always_comb begin
        for (int i = 0; i < 8; i++)
            rdata[i*8 +: 8] = inb[i] ? mem[idx[i]] : 8'h00;
    end

    // R10: first payload byte never changes while locked.
    p_pay_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(mem[0]));

endmodule

// File: rtl/mbox_regfile.sv
// Module: mbox_regfile
// Top of the mailbox window: decodes accesses, routes writes to the
// register block or the payload, and returns registered little-endian
// read data. Assumes one access per cycle and never wr and rd together.
module mbox_regfile
    import mbox_pkg::*;
#(
    parameter int unsigned PAY_BYTES = 2048,
    parameter int unsigned RC_W      = 16,
    parameter int unsigned ADDR_W    = $clog2(PAY_BASE + PAY_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    output logic              eng_req,
    input  logic              eng_done,
    input  logic [RC_W-1:0]   eng_rc
);
    localparam int unsigned PAY_AW = $clog2(PAY_BYTES);

    logic              legal;
    logic              is_pay;
    logic              reg_wr;
    logic              pay_wr;
    logic [3:0]        nbytes;
    logic [PAY_AW-1:0] pay_off;
    logic [31:0]       cap_q;
    logic [31:0]       ctrl_q;
    logic [63:0]       cmd_q;
    logic [63:0]       sts_q;
    logic [63:0]       pay_rdata;
    logic [255:0]      reg_img;
    logic [63:0]       rd_next;

    mbox_access_dec #(.ADDR_W(ADDR_W), .PAY_BYTES(PAY_BYTES)) u_dec (
        .addr    (bus_addr),
        .size    (bus_size),
        .wr      (bus_wr),
        .legal   (legal),
        .is_pay  (is_pay),
        .reg_wr  (reg_wr),
        .pay_wr  (pay_wr),
        .nbytes  (nbytes),
        .pay_off (pay_off)
    );

    mbox_ctrl_regs #(.PAY_BYTES(PAY_BYTES), .RC_W(RC_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_off  (bus_addr[4:0]),
        .size     (bus_size),
        .wdata    (bus_wdata),
        .eng_done (eng_done),
        .eng_rc   (eng_rc),
        .cap_q    (cap_q),
        .ctrl_q   (ctrl_q),
        .cmd_q    (cmd_q),
        .sts_q    (sts_q),
        .eng_req  (eng_req)
    );

    mbox_payload_buf #(.PAY_BYTES(PAY_BYTES)) u_pay (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (pay_wr),
        .lock   (ctrl_q[DB_BIT]),
        .off    (pay_off),
        .nbytes (nbytes),
        .wdata  (bus_wdata),
        .rdata  (pay_rdata)
    );

    // Byte image of the register block; background status always reads zero.
    always_comb begin
        reg_img = '0;
        reg_img[OFF_CAP*8   +: 32] = cap_q;
        reg_img[OFF_CTRL*8  +: 32] = ctrl_q;
        reg_img[OFF_CMD*8   +: 64] = cmd_q;
        reg_img[OFF_STS*8   +: 64] = sts_q;
        reg_img[OFF_BGSTS*8 +: 64] = 64'h0;
    end

    // Assemble the read value at the requested width, upper bytes zero.
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < 8; i++) begin
            if (legal && (4'(i) < nbytes)) begin
                if (is_pay)
                    rd_next[i*8 +: 8] = pay_rdata[i*8 +: 8];
                else
                    rd_next[i*8 +: 8] = reg_img[(32'(bus_addr[4:0]) + 32'(i))*8 +: 8];
            end
        end
    end

    // Register the read result on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_next;
    end

    // R3: a one-byte read leaves the upper bytes zero.
    p_byte_read_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_size == SZ_BYTE) |=> (bus_rdata[63:8] == 56'h0));

    // R7: the request only rises after a register (non-payload) write.
    p_req_from_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_req) |-> $past(reg_wr));

    // R4: an illegal access never writes anything.
    p_illegal_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !legal) |=> ($stable(cmd_q) && $stable(cap_q)));

endmodule

// File: tb/mbox_regfile_test.sv
// Directed bench for mbox_regfile: one task per scenario, each checking
// its own results against values derived from the requirements.
module mbox_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        eng_req;
    logic        eng_done = 1'b0;
    logic [15:0] eng_rc = '0;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    mbox_regfile uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .eng_req   (eng_req),
        .eng_done  (eng_done),
        .eng_rc    (eng_rc)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] s, input logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] s, output logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic engine_done(input logic [15:0] rc);
        @(negedge clk);
        eng_rc = rc; eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        check("R1 eng_req", 64'(eng_req), 64'h0);
        rd(12'h004, 2'd2, v); check("R1 ctrl", v, 64'h0);
        rd(12'h008, 2'd3, v); check("R1 cmd", v, 64'h0);
        rd(12'h010, 2'd3, v); check("R1 sts", v, 64'h0);
        rd(12'h020, 2'd3, v); check("R1 payload", v, 64'h0);
        rd(12'h818, 2'd3, v); check("R1 payload end", v, 64'h0);
    endtask

    task automatic t_capability();
        logic [63:0] v;
        rd(12'h000, 2'd2, v); check("R2 cap word", v, 64'h0000_000B);
        rd(12'h000, 2'd0, v); check("R2 cap exponent byte", v, 64'h0B);
        rd(12'h001, 2'd0, v); check("R2 cap flags clear", v, 64'h0);
    endtask

    task automatic t_widths();
        logic [63:0] v;
        wr(12'h008, 2'd3, 64'h1122_3344_5566_7788);
        rd(12'h008, 2'd3, v); check("R3 8-byte", v, 64'h1122_3344_5566_7788);
        rd(12'h008, 2'd0, v); check("R3 1-byte", v, 64'h88);
        rd(12'h00A, 2'd1, v); check("R3 2-byte", v, 64'h5566);
        rd(12'h00C, 2'd2, v); check("R3 4-byte", v, 64'h1122_3344);
    endtask

    task automatic t_alignment();
        logic [63:0] v;
        wr(12'h00C, 2'd3, 64'hDEAD_DEAD_DEAD_DEAD);
        rd(12'h008, 2'd3, v); check("R4 misaligned write", v, 64'h1122_3344_5566_7788);
        rd(12'h00A, 2'd2, v); check("R4 misaligned read", v, 64'h0);
        rd(12'h820, 2'd2, v); check("R4 out of range read", v, 64'h0);
        wr(12'h021, 2'd1, 64'h7777);
        rd(12'h020, 2'd3, v); check("R4 misaligned payload write", v, 64'h0);
    endtask

    task automatic t_filter32();
        logic [63:0] v;
        wr(12'h008, 2'd2, 64'hAAAA_AAAA);
        rd(12'h008, 2'd3, v); check("R5 4-byte to cmd ignored", v, 64'h1122_3344_5566_7788);
        wr(12'h010, 2'd2, 64'hBBBB_BBBB);
        rd(12'h010, 2'd3, v); check("R5 4-byte to sts ignored", v, 64'h0);
        wr(12'h004, 2'd0, 64'h01);
        rd(12'h004, 2'd2, v); check("R5 1-byte to ctrl ignored", v, 64'h0);
        check("R5 no request", 64'(eng_req), 64'h0);
        wr(12'h004, 2'd2, 64'h0000_00F0);
        rd(12'h004, 2'd2, v); check("R5 ctrl written", v, 64'hF0);
        wr(12'h000, 2'd2, 64'h0000_0055);
        rd(12'h000, 2'd2, v); check("R5 cap written", v, 64'h55);
        wr(12'h000, 2'd2, 64'h0000_000B);
    endtask

    task automatic t_filter64();
        logic [63:0] v;
        wr(12'h010, 2'd3, 64'hCAFE_CAFE_CAFE_CAFE);
        rd(12'h010, 2'd3, v); check("R6 sts ignored", v, 64'h0);
        wr(12'h018, 2'd3, 64'hCAFE_CAFE_CAFE_CAFE);
        rd(12'h018, 2'd3, v); check("R6 bg status ignored", v, 64'h0);
        wr(12'h000, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h000, 2'd3, v); check("R6 8-byte to cap/ctrl ignored", v, 64'h0000_00F0_0000_000B);
    endtask

    task automatic t_payload();
        logic [63:0] v;
        wr(12'h020, 2'd0, 64'hAB);
        wr(12'h021, 2'd0, 64'hCD);
        wr(12'h022, 2'd1, 64'h1234);
        wr(12'h024, 2'd2, 64'hDEAD_BEEF);
        check("R7 no request from payload", 64'(eng_req), 64'h0);
        rd(12'h020, 2'd3, v); check("R7 payload bytes", v, 64'hDEAD_BEEF_1234_CDAB);
        rd(12'h022, 2'd1, v); check("R7 payload half", v, 64'h1234);
        wr(12'h818, 2'd3, 64'h0102_0304_0506_0708);
        rd(12'h818, 2'd3, v); check("R7 last payload dword", v, 64'h0102_0304_0506_0708);
        rd(12'h81F, 2'd0, v); check("R7 last payload byte", v, 64'h01);
    endtask

    task automatic t_doorbell();
        logic [63:0] v;
        wr(12'h004, 2'd2, 64'h1);
        check("R8 request raised", 64'(eng_req), 64'h1);
        wr(12'h008, 2'd3, 64'h9999_9999_9999_9999);
        rd(12'h008, 2'd3, v); check("R10 cmd frozen", v, 64'h1122_3344_5566_7788);
        wr(12'h020, 2'd0, 64'h55);
        rd(12'h020, 2'd0, v); check("R10 payload frozen", v, 64'hAB);
        wr(12'h004, 2'd2, 64'h0);
        rd(12'h004, 2'd2, v); check("R8 doorbell sticky", v, 64'h1);
        check("R8 request held", 64'(eng_req), 64'h1);
        engine_done(16'hBEEF);
        check("R9 request dropped", 64'(eng_req), 64'h0);
        rd(12'h010, 2'd3, v); check("R9 status code", v, 64'h0000_BEEF_0000_0000);
        rd(12'h004, 2'd2, v); check("R9 doorbell cleared", v, 64'h0);
        wr(12'h008, 2'd3, 64'h42);
        rd(12'h008, 2'd3, v); check("R10 cmd writable again", v, 64'h42);
        engine_done(16'h1111);
        rd(12'h010, 2'd3, v); check("R9 stray done ignored", v, 64'h0000_BEEF_0000_0000);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_capability();
        t_widths();
        t_alignment();
        t_filter32();
        t_filter64();
        t_payload();
        t_doorbell();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

endmodule